// File: doc/BRIEF.md
# Sixteen-bit Compare Timer with Pulse Output

This block is a 16-bit up-counting timer that advances once per prescale tick while it is running. Its count is watched by two compare registers: a low compare and a period compare. Reaching the period value ends the cycle, and the count returns to zero on the next tick. Each compare raises its own single-clock interrupt strobe.

In interval mode the block is a periodic interrupt source, and the period compare sets the rate. In pulse mode an output flip-flop inverts at both compare points. The pulse pin then carries a square wave: the period compare sets its frequency and the low compare sets its duty ratio. A polarity input picks active-high or active-low output.

The low compare may be double-buffered. With buffering on, software writes land in a shadow register and reach the low compare only at a period match. Reprogramming the duty ratio therefore never cuts a cycle short.

Top module: `pulse_timer16`

## Requirements
- R1: While `run` is high, each cycle with `tick_en` high is one tick. The count runs 0, 1, ... up to the period compare value and then returns to 0. One period is therefore (period + 1) ticks. Writes to the period compare take effect at once.
- R2: `irq_lo` and `irq_per` are single-clock pulses. Each one rises one clock after a tick whose count equals the low compare or the period compare. Cycles without a tick never raise a strobe.
- R3: With low value L and period P, where L < P, `irq_lo` rises L+1 ticks after `irq_per`. `irq_per` then follows P-L ticks after `irq_lo`.
- R4: In pulse mode (`mode_ppg` = 1, `active_low` = 0), `pulse_out` is low for count values 0 through L and high for count values L+1 through P. It is high for P-L clocks out of each period.
- R5: With `active_low` = 1, `pulse_out` is the inverse of the R4 waveform, and its idle level is 1.
- R6: In interval mode (`mode_ppg` = 0), `pulse_out` stays at its idle level, which is the value of `active_low`.
- R7: One clock after `run` goes low, the count is zero, `pulse_out` sits at its idle level, and no strobe is raised. After `run` rises again, the first `irq_per` comes P+1 ticks later.
- R8: With `dbuf_en` = 0, a write to the low compare (`lo_wr`) takes effect from the next clock, in the period already under way.
- R9: With `dbuf_en` = 1, a low-compare write goes to the shadow register. It takes effect only after the next period match.
- R10: When a buffered low-compare write arrives on the clock of a period match, the low compare takes the earlier shadow value. The new value waits for the following period match.
- R11: After reset, both strobes are 0 and `pulse_out` equals `active_low`. The low compare and the shadow reset to 0, and the period compare resets to 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescale tick; the count advances on cycles where this is high |
| run | input | 1 | 1 = count; 0 = stop, clear the count, idle the output |
| mode_ppg | input | 1 | 0 = interval mode, 1 = pulse mode |
| active_low | input | 1 | Output polarity; 1 inverts the pulse and makes the idle level 1 |
| dbuf_en | input | 1 | 1 = low-compare writes go through the shadow register |
| lo_wr | input | 1 | Write strobe for the low compare |
| lo_wdata | input | 16 | Low compare write value |
| per_wr | input | 1 | Write strobe for the period compare |
| per_wdata | input | 16 | Period compare write value |
| pulse_out | output | 1 | Pulse pin |
| irq_lo | output | 1 | Low-compare match strobe |
| irq_per | output | 1 | Period-match strobe |

## Verification
The two functions that can fall in the same clock are a buffered low-compare write and the shadow-to-compare copy made at a period match. The bench first locks onto one `irq_per` pulse. It then counts exactly P clocks and holds `lo_wr` for the one clock that carries the next match. The result is judged from the gap between `irq_per` and `irq_lo`: in the period that follows, the gap must still match the old shadow value, and one period later it must match the new one.

// File: rtl/pt_pkg.sv
package pt_pkg;
  parameter int TMR_W = 16;
  typedef logic [TMR_W-1:0] cnt_t;

  localparam cnt_t LO_RST  = '0;
  localparam cnt_t PER_RST = '1;

  // Next count: wrap to zero at the top of the period, else step up.
  function automatic cnt_t pt_next_count(input cnt_t cur, input logic at_top);
    return at_top ? '0 : cnt_t'(cur + cnt_t'(1));
  endfunction

  // Output flip-flop: each compare event inverts it once.
  function automatic logic pt_ff_next(input logic cur, input logic ev_lo, input logic ev_per);
    return cur ^ ev_lo ^ ev_per;
  endfunction
endpackage

// File: rtl/pt_counter.sv
module pt_counter
  import pt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic adv,
  input  logic at_top,
  output cnt_t cnt
);
  cnt_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (adv)   cnt_q <= pt_next_count(cnt_q, at_top);
  end

  assign cnt = cnt_q;

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_top) |=> (cnt == '0)); // R1

  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R7

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !adv) |=> $stable(cnt)); // R2
endmodule

// File: rtl/pt_compare.sv
module pt_compare
  import pt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t cnt,
  input  logic adv,
  input  logic dbuf_en,
  input  logic lo_wr,
  input  cnt_t lo_wdata,
  input  logic per_wr,
  input  cnt_t per_wdata,
  output logic at_top,
  output logic hit_lo,
  output logic hit_per
);
  cnt_t lo_q, shadow_q, per_q;
  logic eq_lo, xfer;

  assign eq_lo   = (cnt == lo_q);
  assign at_top  = (cnt == per_q);
  assign hit_lo  = adv && eq_lo;
  assign hit_per = adv && at_top;
  assign xfer    = hit_per && dbuf_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= LO_RST;
    else if (lo_wr)  shadow_q <= lo_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lo_q <= LO_RST;
    else if (xfer)                 lo_q <= shadow_q;
    else if (lo_wr && !dbuf_en)    lo_q <= lo_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       per_q <= PER_RST;
    else if (per_wr)  per_q <= per_wdata;
  end

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !dbuf_en) |=> (lo_q == $past(lo_wdata))); // R8

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && !hit_per) |=> $stable(lo_q)); // R9

  AST_XFER_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && hit_per) |=> (lo_q == $past(shadow_q))); // R10
endmodule

// File: rtl/pt_outctl.sv
module pt_outctl
  import pt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic mode_ppg,
  input  logic active_low,
  input  logic hit_lo,
  input  logic hit_per,
  output logic pulse_out,
  output logic irq_lo,
  output logic irq_per
);
  logic ff_q, irq_lo_q, irq_per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ff_q <= 1'b0;
    else if (!run || !mode_ppg)  ff_q <= 1'b0;
    else                         ff_q <= pt_ff_next(ff_q, hit_lo, hit_per);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_lo_q  <= 1'b0;
      irq_per_q <= 1'b0;
    end else begin
      irq_lo_q  <= hit_lo;
      irq_per_q <= hit_per;
    end
  end

  assign pulse_out = ff_q ^ active_low;
  assign irq_lo    = irq_lo_q;
  assign irq_per   = irq_per_q;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pulse_out == active_low)); // R7

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!irq_lo && !irq_per)); // R7

  AST_INTERVAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ppg |=> (pulse_out == active_low)); // R6

  AST_FF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_ppg && !hit_lo && !hit_per) |=> (pulse_out ^ active_low) == $past(pulse_out ^ active_low)); // R4
endmodule

// File: rtl/pulse_timer16.sv
module pulse_timer16
  import pt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             mode_ppg,
  input  logic             active_low,
  input  logic             dbuf_en,
  input  logic             lo_wr,
  input  logic [TMR_W-1:0] lo_wdata,
  input  logic             per_wr,
  input  logic [TMR_W-1:0] per_wdata,
  output logic             pulse_out,
  output logic             irq_lo,
  output logic             irq_per
);
  logic adv, at_top, hit_lo, hit_per;
  cnt_t cnt;

  assign adv = run && tick_en;

  pt_counter u_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .adv(adv), .at_top(at_top), .cnt(cnt)
  );

  pt_compare u_compare (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .adv(adv), .dbuf_en(dbuf_en),
    .lo_wr(lo_wr), .lo_wdata(lo_wdata), .per_wr(per_wr), .per_wdata(per_wdata),
    .at_top(at_top), .hit_lo(hit_lo), .hit_per(hit_per)
  );

  pt_outctl u_outctl (
    .clk(clk), .rst_n(rst_n), .run(run), .mode_ppg(mode_ppg),
    .active_low(active_low), .hit_lo(hit_lo), .hit_per(hit_per),
    .pulse_out(pulse_out), .irq_lo(irq_lo), .irq_per(irq_per)
  );

  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo || irq_per) |-> $past(tick_en && run)); // R2
endmodule

// File: tb/pulse_timer16_bench.sv
module pulse_timer16_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1, run = 1'b0, mode_ppg = 1'b0, active_low = 1'b0, dbuf_en = 1'b0;
  logic lo_wr = 1'b0, per_wr = 1'b0;
  logic [15:0] lo_wdata = '0, per_wdata = '0;
  logic pulse_out, irq_lo, irq_per;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_div = 1;
  int phase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_timer16 u_pulse_timer16 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .mode_ppg(mode_ppg),
    .active_low(active_low), .dbuf_en(dbuf_en), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
    .per_wr(per_wr), .per_wdata(per_wdata), .pulse_out(pulse_out),
    .irq_lo(irq_lo), .irq_per(irq_per)
  );

  // Tick generator: high on one negedge out of tick_div
  always @(negedge clk) begin
    phase   = (phase + 1 >= tick_div) ? 0 : phase + 1;
    tick_en = (phase == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance one negedge, dropping any single-cycle write
  task automatic step();
    @(negedge clk);
    lo_wr  = 1'b0;
    per_wr = 1'b0;
  endtask

  // Count negedges until the chosen strobe (0 = irq_lo, 1 = irq_per) is seen
  task automatic wait_for(input int which, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!((which == 0) ? irq_lo : irq_per) && n < 70000);
  endtask

  task automatic setup(input int p, input int l, input logic ppg);
    run = 1'b0;
    step();
    per_wr = 1'b1; per_wdata = 16'(p);
    lo_wr  = 1'b1; lo_wdata  = 16'(l);
    mode_ppg = ppg;
    step();
    run = 1'b1;
  endtask

  task automatic t_reset();
    int n;
    check("R11 pulse_out", int'(pulse_out), 0);
    check("R11 irq_lo", int'(irq_lo), 0);
    check("R11 irq_per", int'(irq_per), 0);
    run = 1'b1;
    wait_for(0, n);
    check("R11 low compare 0", n, 1);
    wait_for(1, n);
    check("R11 period FFFF", n, 65535);
  endtask

  task automatic t_interval();
    int n;
    setup(9, 3, 1'b0);
    wait_for(1, n);
    wait_for(1, n);
    check("R1 period spacing", n, 10);
    step();
    check("R2 strobe single clock", int'(irq_per), 0);
    wait_for(0, n);
    check("R3 low after period", n, 3);
    wait_for(1, n);
    check("R3 period after low", n, 6);
    for (int i = 0; i < 10; i++) begin
      step();
      if (pulse_out !== 1'b0) check("R6 interval idle", int'(pulse_out), 0);
    end
    check("R6 interval idle end", int'(pulse_out), 0);
  endtask

  task automatic t_tick_gate();
    int n, w;
    tick_div = 3;
    setup(9, 3, 1'b0);
    wait_for(1, n);
    wait_for(1, n);
    check("R2 tick gated spacing", n, 30);
    w = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (irq_per) w++;
    end
    check("R2 one strobe per period", w, 1);
    tick_div = 1;
  endtask

  task automatic t_ppg(input logic pol);
    int n, hi;
    active_low = pol;
    setup(9, 3, 1'b1);
    wait_for(1, n);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (pulse_out) hi++;
    end
    if (!pol) check("R4 active clocks", hi, 6);
    else      check("R5 inverted high clocks", hi, 4);
    run = 1'b0;
    step();
    check(pol ? "R5 idle level" : "R7 idle level", int'(pulse_out), int'(pol));
    active_low = 1'b0;
  endtask

  task automatic t_stop();
    int n, seen;
    setup(9, 3, 1'b1);
    wait_for(0, n);
    run = 1'b0;
    step();
    check("R7 stopped output idle", int'(pulse_out), 0);
    seen = 0;
    for (int i = 0; i < 25; i++) begin
      step();
      if (irq_lo || irq_per) seen++;
    end
    check("R7 no strobes while stopped", seen, 0);
    run = 1'b1;
    wait_for(1, n);
    check("R7 restart from zero", n, 10);
  endtask

  task automatic t_direct();
    int n;
    dbuf_en = 1'b0;
    setup(9, 3, 1'b1);
    wait_for(1, n);
    lo_wr = 1'b1; lo_wdata = 16'd6;
    wait_for(0, n);
    check("R8 immediate low write", n, 7);
  endtask

  task automatic t_buffered();
    int n;
    dbuf_en = 1'b0;
    setup(9, 3, 1'b1);
    dbuf_en = 1'b1;
    wait_for(1, n);
    lo_wr = 1'b1; lo_wdata = 16'd6;
    wait_for(0, n);
    check("R9 old value this period", n, 4);
    wait_for(1, n);
    wait_for(0, n);
    check("R9 new value next period", n, 7);
    // Coincident write on the clock of the period match
    wait_for(1, n);
    for (int i = 0; i < 9; i++) step();
    lo_wr = 1'b1; lo_wdata = 16'd2;
    wait_for(1, n);
    check("R10 match timing", n, 1);
    wait_for(0, n);
    check("R10 prior shadow used", n, 7);
    wait_for(1, n);
    wait_for(0, n);
    check("R10 new value one period later", n, 3);
    dbuf_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interval();
    t_tick_gate();
    t_ppg(1'b0);
    t_ppg(1'b1);
    t_stop();
    t_direct();
    t_buffered();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule